// File: doc/BRIEF.md
# Push-Button Event Interrupt Logic

This block filters a push-button input that has already been synchronized to the local clock. It records button presses and releases as sticky status flags and raises an active-low interrupt request when a flag is set and the interrupt is not masked. A single deglitch filter measures stability in timer ticks. Its output feeds two places: the sticky edge flags, and a live status bit that shows the filtered pin level.

Software reads the three status bits. It acknowledges an event by writing 1 to the bit position of that flag on a small write-1-to-clear port. The block is active only while the pin is configured for push-button use. In any other pin mode the filter is held at the released level, no events are recorded and the live bit reads 0. Power-on and power-off request generation, and the register decoder that drives the clear port, are outside this block.

Top module: `pb_irq_top`

## Requirements
- R1: The filtered level takes a new value only after the raw input has differed from the filtered level on DEGL_TICKS cycles in which `tick_i` is 1. Cycles with `tick_i` at 0 neither advance nor restart the count.
- R2: If the raw input returns to the filtered level before the count completes, the count restarts from zero.
- R3: When the filtered level changes from 1 (released) to 0 (pressed), `press_flag_o` becomes 1 on the same clock edge and stays 1 until it is cleared.
- R4: When the filtered level changes from 0 to 1, `release_flag_o` becomes 1 on the same clock edge and stays 1 until it is cleared.
- R5: A cycle with `clr_we_i`=1 clears `press_flag_o` when `clr_data_i[0]`=1 and clears `release_flag_o` when `clr_data_i[1]`=1. A 0 in a bit position leaves that flag unchanged.
- R6: If a flag is set and cleared in the same cycle, the flag ends up set.
- R7: `irq_no` is 0 exactly when `irq_mask_i`=0 and at least one edge flag is 1. Otherwise it is 1.
- R8: In push-button mode, `live_level_o` equals the filtered level (1 = released, 0 = pressed). It never affects `irq_no`.
- R9: While `pb_mode_i`=0, `live_level_o` is 0, no edge flag can become set, and the filter is forced to the released level with its count cleared.
- R10: After reset, both flags are 0, `irq_no` is 1 and the filtered level is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pin_sync_i | input | 1 | Synchronized push-button pin level (1 = released) |
| pb_mode_i | input | 1 | Pin is configured as push-button |
| irq_mask_i | input | 1 | 1 masks the push-button interrupt |
| tick_i | input | 1 | Deglitch timer tick, one cycle wide |
| clr_we_i | input | 1 | Write strobe of the clear port |
| clr_data_i | input | 2 | Write-1-to-clear data: bit 0 press flag, bit 1 release flag |
| press_flag_o | output | 1 | Sticky press-detected flag |
| release_flag_o | output | 1 | Sticky release-detected flag |
| live_level_o | output | 1 | Filtered real-time pin level, 0 outside push-button mode |
| irq_no | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with DEGL_TICKS set to 3, so the filter flips on the third qualifying tick. This makes the "one tick short" and "exactly enough" cases only a single step apart. With such a small window, one vector sequence can cover a glitch that restarts the count, both edge flags, each clear bit alone, the mask, and entering and leaving push-button mode while the button is pressed. The same-cycle set and clear race and a reset in the middle of operation are driven as directed cases.

// File: rtl/pb_irq_pkg.sv
package pb_irq_pkg;
  // Flag positions on the clear port and in the flag vector
  localparam int unsigned FLAG_PRESS   = 0;
  localparam int unsigned FLAG_RELEASE = 1;
  localparam int unsigned NUM_FLAGS    = 2;

  // Idle level of the pin (external pull-up, button open)
  localparam logic LEVEL_RELEASED = 1'b1;
endpackage

// File: rtl/pb_deglitch.sv
module pb_deglitch
  import pb_irq_pkg::*;
#(
  parameter int unsigned DEGL_TICKS = 16,
  localparam int unsigned CNT_W     = $clog2(DEGL_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic raw_i,
  input  logic tick_i,
  output logic level_o,
  output logic fall_o,
  output logic rise_o
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEGL_TICKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;
  logic             differ;
  logic             expire;

  assign differ = (raw_i != lvl_q);
  assign expire = enable_i && differ && tick_i && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (!enable_i) begin
      cnt_d = '0;
      lvl_d = LEVEL_RELEASED;
    end else if (!differ) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (cnt_q == CNT_LAST) begin
        cnt_d = '0;
        lvl_d = raw_i;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= LEVEL_RELEASED;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign level_o = lvl_q;
  assign fall_o  = expire &&  lvl_q;
  assign rise_o  = expire && !lvl_q;

endmodule

// File: rtl/pb_sticky_flags.sv
module pb_sticky_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_bits_i,
  output logic [N-1:0] flag_o
);

  for (genvar g = 0; g < N; g++) begin : g_flag
    logic flag_q, flag_d;

    // set wins over a simultaneous clear
    always_comb begin
      flag_d = flag_q;
      if (clr_we_i && clr_bits_i[g]) flag_d = 1'b0;
      if (set_i[g])                  flag_d = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= flag_d;
    end

    assign flag_o[g] = flag_q;
  end

endmodule

// File: rtl/pb_irq_top.sv
module pb_irq_top
  import pb_irq_pkg::*;
#(
  parameter int unsigned DEGL_TICKS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_sync_i,
  input  logic       pb_mode_i,
  input  logic       irq_mask_i,
  input  logic       tick_i,
  input  logic       clr_we_i,
  input  logic [1:0] clr_data_i,
  output logic       press_flag_o,
  output logic       release_flag_o,
  output logic       live_level_o,
  output logic       irq_no
);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic                 level;
  logic                 fall_evt;
  logic                 rise_evt;
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] flags;

  pb_deglitch #(
    .DEGL_TICKS (DEGL_TICKS)
  ) u_degl (
    .clk_i    (clk_i),
    .rst_ni   (rst_int_n),
    .enable_i (pb_mode_i),
    .raw_i    (pin_sync_i),
    .tick_i   (tick_i),
    .level_o  (level),
    .fall_o   (fall_evt),
    .rise_o   (rise_evt)
  );

  always_comb begin
    set_vec               = '0;
    set_vec[FLAG_PRESS]   = fall_evt;
    set_vec[FLAG_RELEASE] = rise_evt;
  end

  pb_sticky_flags #(
    .N (NUM_FLAGS)
  ) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_int_n),
    .set_i      (set_vec),
    .clr_we_i   (clr_we_i),
    .clr_bits_i (clr_data_i),
    .flag_o     (flags)
  );

  assign press_flag_o   = flags[FLAG_PRESS];
  assign release_flag_o = flags[FLAG_RELEASE];
  assign live_level_o   = pb_mode_i & level;
  assign irq_no         = ~(|(flags & {NUM_FLAGS{~irq_mask_i}}));

endmodule

// File: rtl/pb_irq_checker.sv
module pb_irq_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pb_mode_i,
  input logic       irq_mask_i,
  input logic       tick_i,
  input logic       clr_we_i,
  input logic [1:0] clr_data_i,
  input logic       press_flag_o,
  input logic       release_flag_o,
  input logic       live_level_o,
  input logic       irq_no
);

  // R7: a request needs an unmasked flag
  p_irq_source_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> (!irq_mask_i && (press_flag_o || release_flag_o)));

  // R9: live bit is 0 outside push-button mode
  p_live_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pb_mode_i |-> !live_level_o);

  // R9: no flag sets when the edge sees non-button mode
  p_no_set_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pb_mode_i |=> (!$rose(press_flag_o) && !$rose(release_flag_o)));

  // R5: press flag sticks unless cleared
  p_press_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (press_flag_o && !(clr_we_i && clr_data_i[0])) |=> press_flag_o);

  // R5: release flag sticks unless cleared
  p_release_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_flag_o && !(clr_we_i && clr_data_i[1])) |=> release_flag_o);

  // R1: filtered level only moves on a tick
  p_live_needs_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pb_mode_i && !tick_i) |=> (!pb_mode_i || $stable(live_level_o)));

endmodule

bind pb_irq_top pb_irq_checker u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .pb_mode_i      (pb_mode_i),
  .irq_mask_i     (irq_mask_i),
  .tick_i         (tick_i),
  .clr_we_i       (clr_we_i),
  .clr_data_i     (clr_data_i),
  .press_flag_o   (press_flag_o),
  .release_flag_o (release_flag_o),
  .live_level_o   (live_level_o),
  .irq_no         (irq_no)
);

// File: tb/tb_pb_irq_top.sv
module tb_pb_irq_top;
  localparam int unsigned DEGL = 3;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pin_sync_i = 1'b1;
  logic       pb_mode_i = 1'b1;
  logic       irq_mask_i = 1'b0;
  logic       tick_i = 1'b0;
  logic       clr_we_i = 1'b0;
  logic [1:0] clr_data_i = 2'b00;
  logic       press_flag_o, release_flag_o, live_level_o, irq_no;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  pb_irq_top #(.DEGL_TICKS(DEGL)) dut (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .pin_sync_i     (pin_sync_i),
    .pb_mode_i      (pb_mode_i),
    .irq_mask_i     (irq_mask_i),
    .tick_i         (tick_i),
    .clr_we_i       (clr_we_i),
    .clr_data_i     (clr_data_i),
    .press_flag_o   (press_flag_o),
    .release_flag_o (release_flag_o),
    .live_level_o   (live_level_o),
    .irq_no         (irq_no)
  );

  // {pin, mode, mask, ticks[3:0], clr[1:0], exp press, exp release, exp live, exp irq_n}
  localparam int NV = 15;
  localparam logic [12:0] VEC [NV] = '{
    {1'b1,1'b1,1'b0,4'd0,2'b00, 1'b0,1'b0,1'b1,1'b1}, // R10 idle
    {1'b0,1'b1,1'b0,4'd2,2'b00, 1'b0,1'b0,1'b1,1'b1}, // R1 one tick short
    {1'b0,1'b1,1'b0,4'd1,2'b00, 1'b1,1'b0,1'b0,1'b0}, // R3 R1 flip on third tick
    {1'b1,1'b1,1'b0,4'd1,2'b00, 1'b1,1'b0,1'b0,1'b0}, // R2 glitch starts
    {1'b0,1'b1,1'b0,4'd2,2'b00, 1'b1,1'b0,1'b0,1'b0}, // R2 back to level
    {1'b1,1'b1,1'b0,4'd2,2'b00, 1'b1,1'b0,1'b0,1'b0}, // R2 restarted count short
    {1'b1,1'b1,1'b0,4'd1,2'b00, 1'b1,1'b1,1'b1,1'b0}, // R4 release
    {1'b1,1'b1,1'b0,4'd0,2'b01, 1'b0,1'b1,1'b1,1'b0}, // R5 clear press only
    {1'b1,1'b1,1'b0,4'd0,2'b10, 1'b0,1'b0,1'b1,1'b1}, // R5 R7 clear release
    {1'b0,1'b1,1'b1,4'd3,2'b00, 1'b1,1'b0,1'b0,1'b1}, // R7 masked
    {1'b0,1'b1,1'b0,4'd0,2'b00, 1'b1,1'b0,1'b0,1'b0}, // R7 unmasked
    {1'b0,1'b1,1'b0,4'd0,2'b01, 1'b0,1'b0,1'b0,1'b1}, // R8 live stays, no irq
    {1'b0,1'b0,1'b0,4'd3,2'b00, 1'b0,1'b0,1'b0,1'b1}, // R9 mode off while pressed
    {1'b1,1'b0,1'b0,4'd3,2'b00, 1'b0,1'b0,1'b0,1'b1}, // R9 release ignored
    {1'b1,1'b1,1'b0,4'd0,2'b00, 1'b0,1'b0,1'b1,1'b1}  // R9 back in mode, released
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic ep, input logic er,
                         input logic el, input logic ei);
    chk(req, "press_flag",   press_flag_o,   ep);
    chk(req, "release_flag", release_flag_o, er);
    chk(req, "live_level",   live_level_o,   el);
    chk(req, "irq_n",        irq_no,         ei);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk_i);
    chk_all("R10", 1'b0, 1'b0, 1'b1, 1'b1);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      pin_sync_i = VEC[i][12];
      pb_mode_i  = VEC[i][11];
      irq_mask_i = VEC[i][10];
      clr_data_i = VEC[i][5:4];
      clr_we_i   = |VEC[i][5:4];
      tick_i     = 1'b0;
      @(negedge clk_i);
      clr_we_i   = 1'b0;
      clr_data_i = 2'b00;
      for (int t = 0; t < int'(VEC[i][9:6]); t++) begin
        tick_i = 1'b1;
        @(negedge clk_i);
      end
      tick_i = 1'b0;
      chk_all($sformatf("vec%0d", i), VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R6: clear of press flag in the very cycle it sets
    pin_sync_i = 1'b0;
    repeat (2) begin
      tick_i = 1'b1;
      @(negedge clk_i);
    end
    clr_we_i   = 1'b1;
    clr_data_i = 2'b01;
    @(negedge clk_i);
    tick_i     = 1'b0;
    clr_we_i   = 1'b0;
    clr_data_i = 2'b00;
    chk("R6", "press_flag set wins", press_flag_o, 1'b1);
    chk("R6", "irq_n", irq_no, 1'b0);

    // R1: ticks absent, no progress
    pin_sync_i = 1'b1;
    repeat (10) @(negedge clk_i);
    chk("R1", "live without ticks", live_level_o, 1'b0);

    // R10: reset in the middle of operation
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk_all("R10", 1'b0, 1'b0, 1'b1, 1'b1);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    finish_run();
  end
endmodule